// File: doc/BRIEF.md
# Serial-Timed 8-bit Accumulator Processor

This block is a small single-accumulator processor core with four 8-bit registers: accumulator, memory buffer, memory address and program counter. Every instruction is one byte. It runs as a sequence of major cycles: a fetch, an optional defer for indirect addressing, and an execute. Each major cycle lasts a fixed number of clock beats, so an instruction takes two or three major cycles. Memory lives outside the block. It is a 256-byte synchronous RAM reached through an address bus, a write-data bus, a write enable and a read-data bus that returns data one clock after the address.

Memory-reference instructions take their operand address from the page of the instruction that holds them. The upper nibble comes from that instruction's own program counter value and the lower nibble from the instruction. One level of indirection is available. The operate group changes the accumulator and tests it. The I/O group drives a one-beat strobe with a function code, can skip the next instruction on a device flag, and can load the accumulator from a device byte.

A console starts execution with a run pulse and stops it with a halt request. It watches the run and phase outputs.

Top module: `accCore`

## Requirements
- R1: After reset, running and all three phase outputs are low, memWe and ioStb are low, memAddr is 0 and ioWData (the accumulator) is 0. The program counter is 0.
- R2: A runReq pulse while idle starts a FETCH. Every major cycle lasts BEATS clock cycles (24 by default), and exactly one phase output is high while running. A direct instruction takes FETCH+EXEC and an indirect one takes FETCH+DEFER+EXEC.
- R3: The opcode is instr[7:5]. Opcodes 0 to 5 reference memory, and instr[4] requests indirection. The address is {PC[7:4], instr[3:0]} using the instruction's own PC. When instr[4]=1, a DEFER cycle reads that location and the byte read becomes the address.
- R4: Opcode 0 (AND) sets AC to AC & Mem[A]. Opcode 1 (TAD) sets AC to AC + Mem[A] modulo 256.
- R5: Opcode 2 (ISZ) writes Mem[A]+1 (mod 256) back to memory. When that result is 0 it skips the next instruction.
- R6: Opcode 3 (DCA) writes AC to Mem[A] and then clears AC.
- R7: Opcode 4 (JMS) writes the incremented PC to Mem[A] and continues at A+1. Opcode 5 (JMP) continues at A, so JMP indirect through the entry location returns from a JMS.
- R8: Opcode 6 with instr[4]=0 applies its functions in order from bit 3 down to bit 0: bit3 clears AC, bit2 complements AC, bit1 increments AC, bit0 rotates AC left by one (bit 7 into bit 0).
- R9: Opcode 6 with instr[4]=1 works as follows. Bit3 skips when AC is 0 or AC[7] is 1. Bit2 skips when AC is nonzero. Both tests use AC before bit1 clears AC, and the skip happens at most once. Bit0 stops the processor after this instruction.
- R10: Opcode 7 pulses ioStb for one beat during EXEC with ioCode = instr[4:0]. With instr[2]=1 it skips when ioFlag is high. With instr[4]=0 and instr[1]=1 it loads AC from ioRData.
- R11: haltReq is sampled only at the end of EXEC. Running then drops after a whole instruction, and a later runReq fetches from the next instruction's address.
- R12: memWe is high for exactly one beat in EXEC of ISZ, DCA and JMS, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runReq | input | 1 | Start execution at the current PC when idle |
| haltReq | input | 1 | Stop after the current instruction |
| memRData | input | 8 | Read data, valid one clock after memAddr |
| ioFlag | input | 1 | Flag of the device addressed by ioCode |
| ioRData | input | 8 | Input byte from the addressed device |
| memAddr | output | 8 | Memory address (MA register) |
| memWData | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| running | output | 1 | Processor is executing |
| phFetch | output | 1 | FETCH major cycle active |
| phDefer | output | 1 | DEFER major cycle active |
| phExec | output | 1 | EXEC major cycle active |
| ioStb | output | 1 | One-beat I/O transfer strobe |
| ioCode | output | 5 | I/O function and device code (instr[4:0]) |
| ioWData | output | 8 | Accumulator value offered to output devices |

## Verification
A wrong program counter shows on memAddr no later than the next FETCH, which is at most one major cycle after the instruction that corrupted it. A wrong accumulator shows at once on ioWData and in the next DCA write. A beat counter that drifts changes the length of a run. Every run is therefore timed in clock cycles and compared with 24 times the number of major cycles the program needs. Sweeps over operand pairs and over every combination of operate bits compare the results with values the bench computes by arithmetic.

// File: rtl/accPkg.sv
package accPkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_FETCH, PH_DEFER, PH_EXEC} phase_t;

  typedef struct packed {
    logic start;
    logic capIr;
    logic capMb;
    logic wrBeat;
    logic endFetch;
    logic endDefer;
    logic endExec;
  } strobes_t;

  localparam logic [2:0] OP_AND = 3'd0;
  localparam logic [2:0] OP_TAD = 3'd1;
  localparam logic [2:0] OP_ISZ = 3'd2;
  localparam logic [2:0] OP_DCA = 3'd3;
  localparam logic [2:0] OP_JMS = 3'd4;
  localparam logic [2:0] OP_JMP = 3'd5;
  localparam logic [2:0] OP_OPR = 3'd6;
  localparam logic [2:0] OP_IO  = 3'd7;
endpackage

// File: rtl/accControl.sv
module accControl
  import accPkg::*;
#(
  parameter int BEATS    = 24,
  parameter int CAP_BEAT = 2,
  parameter int WR_BEAT  = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runReq,
  input  logic          haltReq,
  input  logic [DW-1:0] ir,
  output phase_t        phase,
  output strobes_t      st
);
  localparam int BW = $clog2(BEATS);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);
  localparam logic [BW-1:0] CAPB = BW'(CAP_BEAT);
  localparam logic [BW-1:0] WRB  = BW'(WR_BEAT);

  logic [BW-1:0] beat;
  logic lastBeat, memRef, indirect, hltOp;

  assign lastBeat = (beat == LAST);
  assign memRef   = (ir[7:5] <= OP_JMP);
  assign indirect = ir[4];
  assign hltOp    = (ir[7:5] == OP_OPR) && ir[4] && ir[0];

  always_comb begin
    st          = '0;
    st.start    = (phase == PH_IDLE) && runReq;
    st.capIr    = (phase == PH_FETCH) && (beat == CAPB);
    st.capMb    = ((phase == PH_DEFER) || (phase == PH_EXEC)) && (beat == CAPB);
    st.wrBeat   = (phase == PH_EXEC) && (beat == WRB);
    st.endFetch = (phase == PH_FETCH) && lastBeat;
    st.endDefer = (phase == PH_DEFER) && lastBeat;
    st.endExec  = (phase == PH_EXEC) && lastBeat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      beat  <= '0;
    end else if (phase == PH_IDLE) begin
      beat <= '0;
      if (runReq) phase <= PH_FETCH;
    end else begin
      beat <= lastBeat ? '0 : beat + 1'b1;
      if (lastBeat) begin
        case (phase)
          PH_FETCH: phase <= (memRef && indirect) ? PH_DEFER : PH_EXEC;
          PH_DEFER: phase <= PH_EXEC;
          PH_EXEC:  phase <= (haltReq || hltOp) ? PH_IDLE : PH_FETCH;
          default:  phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/accDatapath.sv
module accDatapath
  import accPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      st,
  input  logic [DW-1:0] memRData,
  input  logic          ioFlag,
  input  logic [DW-1:0] ioRData,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWData,
  output logic          memWe,
  output logic          ioStb,
  output logic [4:0]    ioCode,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] ir
);
  localparam int PB = DW / 2;

  logic [DW-1:0] pc, ma, mb;
  logic [DW-1:0] acNext, pcNext, mbInc, oprAcc;
  logic [2:0]    op;
  logic          memRef, oprSkip;

  assign op      = ir[7:5];
  assign memRef  = (op <= OP_JMP);
  assign mbInc   = mb + 1'b1;
  assign memAddr = ma;
  assign ioCode  = ir[4:0];

  always_comb begin
    oprAcc = acc;
    if (ir[3]) oprAcc = '0;
    if (ir[2]) oprAcc = ~oprAcc;
    if (ir[1]) oprAcc = oprAcc + 1'b1;
    if (ir[0]) oprAcc = {oprAcc[DW-2:0], oprAcc[DW-1]};
    oprSkip = (ir[3] && ((acc == '0) || acc[DW-1])) || (ir[2] && (acc != '0));
  end

  always_comb begin
    acNext   = acc;
    pcNext   = pc;
    memWData = acc;
    case (op)
      OP_AND: acNext = acc & mb;
      OP_TAD: acNext = acc + mb;
      OP_ISZ: begin
        memWData = mbInc;
        if (mbInc == '0) pcNext = pc + 1'b1;
      end
      OP_DCA: acNext = '0;
      OP_JMS: begin
        memWData = pc;
        pcNext   = ma + 1'b1;
      end
      OP_JMP: pcNext = ma;
      OP_OPR: begin
        if (!ir[4]) acNext = oprAcc;
        else begin
          if (oprSkip) pcNext = pc + 1'b1;
          if (ir[1]) acNext = '0;
        end
      end
      default: begin
        if (ir[2] && ioFlag) pcNext = pc + 1'b1;
        if (!ir[4] && ir[1]) acNext = ioRData;
      end
    endcase
    memWe = st.wrBeat && ((op == OP_ISZ) || (op == OP_DCA) || (op == OP_JMS));
    ioStb = st.wrBeat && (op == OP_IO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= '0;
      ma  <= '0;
      mb  <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (st.start) ma <= pc;
      if (st.capIr) ir <= memRData;
      if (st.capMb) mb <= memRData;
      if (st.endFetch) begin
        pc <= pc + 1'b1;
        if (memRef) ma <= {pc[DW-1:PB], ir[PB-1:0]};
      end
      if (st.endDefer) ma <= mb;
      if (st.endExec) begin
        acc <= acNext;
        pc  <= pcNext;
        ma  <= pcNext;
      end
    end
  end
endmodule

// File: rtl/accCore.sv
module accCore
  import accPkg::*;
#(
  parameter int BEATS = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runReq,
  input  logic       haltReq,
  input  logic [7:0] memRData,
  input  logic       ioFlag,
  input  logic [7:0] ioRData,
  output logic [7:0] memAddr,
  output logic [7:0] memWData,
  output logic       memWe,
  output logic       running,
  output logic       phFetch,
  output logic       phDefer,
  output logic       phExec,
  output logic       ioStb,
  output logic [4:0] ioCode,
  output logic [7:0] ioWData
);
  phase_t        phase;
  strobes_t      st;
  logic [DW-1:0] ir;

  accControl #(.BEATS(BEATS)) i_accControl (
    .clk(clk), .rstN(rstN), .runReq(runReq), .haltReq(haltReq),
    .ir(ir), .phase(phase), .st(st)
  );

  accDatapath i_accDatapath (
    .clk(clk), .rstN(rstN), .st(st), .memRData(memRData),
    .ioFlag(ioFlag), .ioRData(ioRData), .memAddr(memAddr),
    .memWData(memWData), .memWe(memWe), .ioStb(ioStb),
    .ioCode(ioCode), .acc(ioWData), .ir(ir)
  );

  assign running = (phase != PH_IDLE);
  assign phFetch = (phase == PH_FETCH);
  assign phDefer = (phase == PH_DEFER);
  assign phExec  = (phase == PH_EXEC);
endmodule

// File: rtl/accCoreChecker.sv
module accCoreChecker #(
  parameter int BEATS = 24
) (
  input logic clk,
  input logic rstN,
  input logic running,
  input logic phFetch,
  input logic phDefer,
  input logic phExec,
  input logic memWe,
  input logic ioStb
);
  localparam int CW = $clog2(BEATS + 1) + 1;

  logic [2:0]    ph, phPrev;
  logic [CW-1:0] cnt;

  assign ph = {phFetch, phDefer, phExec};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phPrev <= '0;
      cnt    <= '0;
    end else begin
      phPrev <= ph;
      if (ph != phPrev && phPrev != '0) begin
        p_major_len_r2: assert (cnt == CW'(BEATS))
          else $error("major cycle lasted %0d beats", cnt);
      end
      if (ph != phPrev) cnt <= CW'(1);
      else if (ph != '0) cnt <= cnt + 1'b1;
    end
  end

  p_phase_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({phFetch, phDefer, phExec}) == (running ? 1 : 0));

  p_we_in_exec_r12: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> phExec);

  p_we_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  p_io_in_exec_r10: assert property (@(posedge clk) disable iff (!rstN)
    ioStb |-> (phExec && !memWe));

  p_io_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    ioStb |=> !ioStb);

  p_defer_after_fetch_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phDefer) |-> $past(phFetch));

  p_stop_after_exec_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(phExec));
endmodule

bind accCore accCoreChecker #(.BEATS(BEATS)) i_accCoreChecker (
  .clk(clk), .rstN(rstN), .running(running), .phFetch(phFetch),
  .phDefer(phDefer), .phExec(phExec), .memWe(memWe), .ioStb(ioStb)
);

// File: tb/test_accCore.sv
`timescale 1ns/1ps
module test_accCore;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runReq = 1'b0;
  logic       haltReq = 1'b0;
  logic [7:0] memRData;
  logic       ioFlag = 1'b0;
  logic [7:0] ioRData = 8'h00;
  logic [7:0] memAddr, memWData, ioWData;
  logic       memWe, running, phFetch, phDefer, phExec, ioStb;
  logic [4:0] ioCode;

  logic [7:0] mem [256];
  int checks = 0;
  int errors = 0;
  int ticks = 0;
  int weCnt = 0;
  int stbCnt = 0;
  int lastCode = 0;

  accCore i_accCore (
    .clk(clk), .rstN(rstN), .runReq(runReq), .haltReq(haltReq),
    .memRData(memRData), .ioFlag(ioFlag), .ioRData(ioRData),
    .memAddr(memAddr), .memWData(memWData), .memWe(memWe),
    .running(running), .phFetch(phFetch), .phDefer(phDefer),
    .phExec(phExec), .ioStb(ioStb), .ioCode(ioCode), .ioWData(ioWData)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWData;
    memRData <= mem[memAddr];
  end

  always @(negedge clk) begin
    if (memWe) weCnt++;
    if (ioStb) begin
      stbCnt++;
      lastCode = int'(ioCode);
    end
  end

  always @(posedge clk) begin
    ticks++;
    if (ticks == 190000) begin
      errors++;
      $display("FAIL R2 watchdog expired: actual %0d cycles expected fewer", ticks);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic runProg(output int cyc);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    weCnt = 0;
    stbCnt = 0;
    runReq = 1'b1;
    @(negedge clk);
    runReq = 1'b0;
    cyc = 0;
    while (running && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] pick(input int i);
    if (i == 0) return 8'h00;
    if (i == 1) return 8'hFF;
    return 8'((i * 23) & 255);
  endfunction

  function automatic logic [7:0] opr1(input logic [3:0] k, input logic [7:0] a);
    logic [7:0] r;
    r = a;
    if (k[3]) r = 8'h00;
    if (k[2]) r = ~r;
    if (k[1]) r = r + 8'd1;
    if (k[0]) r = {r[6:0], r[7]};
    return r;
  endfunction

  initial begin
    int cyc;
    logic [7:0] vals [4];
    clearMem();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 running", int'(running), 0);
    chk("R1 phases", int'({phFetch, phDefer, phExec}), 0);
    chk("R1 memWe", int'(memWe), 0);
    chk("R1 ioStb", int'(ioStb), 0);
    chk("R1 memAddr", int'(memAddr), 0);
    chk("R1 acc", int'(ioWData), 0);

    // R2: direct program CLA, TAD, HLT = 6 major cycles
    clearMem();
    mem[0] = 8'hC8; mem[1] = 8'h2F; mem[2] = 8'hD1; mem[15] = 8'h2A;
    runProg(cyc);
    chk("R2 direct length", cyc, 6 * 24);
    chk("R4 tad load", int'(ioWData), 8'h2A);
    // R2/R3: indirect TAD adds a DEFER cycle
    clearMem();
    mem[0] = 8'hC8; mem[1] = 8'h3F; mem[2] = 8'hD1; mem[15] = 8'h0E; mem[14] = 8'h07;
    runProg(cyc);
    chk("R2 indirect length", cyc, 7 * 24);
    chk("R3 indirect operand", int'(ioWData), 7);

    // R4/R6/R12: sum and AND sweep
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        logic [7:0] a, b;
        a = pick(i);
        b = pick(j * 5 + 1);
        clearMem();
        mem[0] = 8'hC8; mem[1] = 8'h2E; mem[2] = 8'h2F; mem[3] = 8'h6D;
        mem[4] = 8'h2E; mem[5] = 8'h0F; mem[6] = 8'hD1;
        mem[14] = a; mem[15] = b;
        runProg(cyc);
        chk("R4 tad sum", int'(mem[13]), int'(8'(a + b)));
        chk("R6 dca clears then and", int'(ioWData), int'(a & b));
        chk("R12 one write", weCnt, 1);
      end
    end

    // R8: all group-1 operate combinations
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'h81; vals[3] = 8'h5A;
    for (int v = 0; v < 4; v++) begin
      for (int k = 0; k < 16; k++) begin
        clearMem();
        mem[0] = 8'hC8; mem[1] = 8'h2F; mem[2] = 8'hC0 | 8'(k); mem[3] = 8'hD1;
        mem[15] = vals[v];
        runProg(cyc);
        chk("R8 operate group 1", int'(ioWData), int'(opr1(4'(k), vals[v])));
      end
    end

    // R9: skip tests, skip skips TAD of 1
    vals[0] = 8'h00; vals[1] = 8'h80; vals[2] = 8'h01; vals[3] = 8'h7F;
    for (int v = 0; v < 4; v++) begin
      for (int s = 0; s < 4; s++) begin
        logic sk;
        sk = (s[1] && (vals[v] == 8'h00 || vals[v][7])) || (s[0] && vals[v] != 8'h00);
        clearMem();
        mem[0] = 8'hC8; mem[1] = 8'h2F; mem[2] = 8'hD0 | 8'(s << 2);
        mem[3] = 8'h2E; mem[4] = 8'hD1; mem[14] = 8'h01; mem[15] = vals[v];
        runProg(cyc);
        chk("R9 skip", int'(ioWData), int'(sk ? vals[v] : 8'(vals[v] + 1)));
      end
    end
    clearMem();
    mem[0] = 8'hC8; mem[1] = 8'h2F; mem[2] = 8'hD2; mem[3] = 8'h2E; mem[4] = 8'hD1;
    mem[14] = 8'h01; mem[15] = 8'h55;
    runProg(cyc);
    chk("R9 clear", int'(ioWData), 1);
    clearMem();
    mem[0] = 8'hC8; mem[1] = 8'h2F; mem[2] = 8'hD3; mem[3] = 8'h2E; mem[15] = 8'h55;
    runProg(cyc);
    chk("R9 clear and stop acc", int'(ioWData), 0);
    chk("R9 clear and stop length", cyc, 6 * 24);

    // R5: ISZ with and without wrap
    clearMem();
    mem[0] = 8'hC8; mem[1] = 8'h4F; mem[2] = 8'hC2; mem[3] = 8'hD1; mem[15] = 8'hFF;
    runProg(cyc);
    chk("R5 isz wrap value", int'(mem[15]), 0);
    chk("R5 isz skipped", int'(ioWData), 0);
    chk("R12 isz one write", weCnt, 1);
    clearMem();
    mem[0] = 8'hC8; mem[1] = 8'h4F; mem[2] = 8'hC2; mem[3] = 8'hD1; mem[15] = 8'h05;
    runProg(cyc);
    chk("R5 isz value", int'(mem[15]), 6);
    chk("R5 isz no skip", int'(ioWData), 1);

    // R7: JMS and return by indirect JMP
    clearMem();
    mem[0] = 8'h88; mem[1] = 8'hD1; mem[9] = 8'hC2; mem[10] = 8'hB8;
    runProg(cyc);
    chk("R7 return address", int'(mem[8]), 1);
    chk("R7 subroutine ran", int'(ioWData), 1);
    chk("R7 length", cyc, (2 + 2 + 3 + 2) * 24);

    // R3: page-relative and indirect addressing away from page 0
    clearMem();
    mem[0] = 8'hBF; mem[15] = 8'h30; mem[8'h30] = 8'hC8; mem[8'h31] = 8'h25;
    mem[8'h32] = 8'h36; mem[8'h33] = 8'hD1; mem[8'h35] = 8'h5A; mem[8'h36] = 8'h05;
    mem[8'h05] = 8'h11;
    runProg(cyc);
    chk("R3 page relative", int'(ioWData), 8'h6B);
    chk("R3 length", cyc, 12 * 24);

    // R10: I/O load, strobes, flag skip
    for (int f = 0; f < 2; f++) begin
      clearMem();
      mem[0] = 8'hC8; mem[1] = 8'hE2; mem[2] = 8'hE4; mem[3] = 8'hC2; mem[4] = 8'hD1;
      ioRData = 8'h3C;
      ioFlag = f[0];
      runProg(cyc);
      chk("R10 io load and skip", int'(ioWData), f == 1 ? 8'h3C : 8'h3D);
      chk("R10 strobe count", stbCnt, 2);
      chk("R10 last code", lastCode, 5'h04);
    end
    ioFlag = 1'b0;

    // R11: halt request at instruction boundary and resume
    clearMem();
    mem[0] = 8'hC2; mem[1] = 8'hA0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    runReq = 1'b1;
    @(negedge clk);
    runReq = 1'b0;
    cyc = 0;
    while (running && cyc < 5000) begin
      if (cyc == 200) haltReq = 1'b1;
      cyc++;
      @(negedge clk);
    end
    haltReq = 1'b0;
    chk("R11 whole instructions", cyc % 48, 0);
    chk("R11 acc count", int'(ioWData), (cyc / 48 + 1) / 2);
    runReq = 1'b1;
    @(negedge clk);
    runReq = 1'b0;
    chk("R11 resume fetch", int'(phFetch), 1);
    chk("R11 resume address", int'(memAddr), (cyc / 48) % 2);
    haltReq = 1'b1;
    cyc = 0;
    while (running && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
    haltReq = 1'b0;
    chk("R11 stopped", int'(running), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule